// File: doc/BRIEF.md
# Hybrid branch direction predictor

This block guesses whether a conditional branch will be taken. It runs three direction predictors side by side. The first is a bimodal table indexed by the branch address. The second is a global-history table indexed by the address XOR the history. The third is a global-history table that uses a skewed hash of the address and the history. All three are tables of 2-bit saturating counters. Because each table uses a different index function, two branches that collide in one table seldom collide in another.

A fourth table of 2-bit counters, indexed by the branch address, learns whether the bimodal or the XOR-indexed global component has been the better one for that branch. In selector mode that counter picks the final direction. In vote mode the final direction is the majority of the three component predictions.

The lookup is combinational. It reports the three component predictions, the selector's choice, the final direction and the history it used. The caller keeps that history and returns it on the update port when the branch resolves. An update trains all three components. It moves the selector counter only when the bimodal and the XOR-indexed global predictions disagree. It also shifts the resolved outcome into the global history register.

Top module: `hybrid_bp`

## Requirements
- R1: After reset every component counter holds 01 (weakly not taken). Every selector counter holds 01 (weakly bimodal). The global history register is zero. So every lookup then returns not taken from all components, selector choice 0, and history 0.
- R2: Counters are 2-bit values from 0 to 3. A taken outcome adds one, saturating at 3. A not-taken outcome subtracts one, saturating at 0. A counter predicts taken when its bit 1 is set.
- R3: With N index bits, the bimodal and selector index is pc[N-1:0]. The XOR-indexed global index is pc[N-1:0] XOR hist. The skewed index is pc[N-1:0] rotated left by one bit, XOR the bit-reversed history (hist bit i goes to position N-1-i).
- R4: With the vote-mode input at 0, pred_use_gsh_o is bit 1 of the selector counter. The final direction is the XOR-indexed global prediction when that bit is 1, and the bimodal prediction when it is 0.
- R5: With the vote-mode input at 1, the final direction is the majority of the three component predictions.
- R6: Each update steps all three component counters toward the outcome. The indexes are formed from upd_pc_i and upd_hist_i. This happens in either mode and whatever the selector chose.
- R7: On an update, the selector counter changes only if the bimodal and XOR-indexed global counters read at update time predict different directions. It adds one when the global component was right and subtracts one when the bimodal component was right, saturating as in R2.
- R8: Each update shifts the global history left by one and places the outcome in bit 0. pred_hist_o shows the current history.
- R9: A lookup in the same cycle as an update sees the table and history contents from before that update. The update becomes visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_vote_i | input | 1 | 1: majority vote of three components; 0: selector picks |
| pred_pc_i | input | PC_W | Address of the branch being looked up |
| pred_bim_o | output | 1 | Bimodal component prediction |
| pred_gsh_o | output | 1 | XOR-indexed global component prediction |
| pred_skw_o | output | 1 | Skew-indexed global component prediction |
| pred_use_gsh_o | output | 1 | Selector choice, 1 = global component |
| pred_taken_o | output | 1 | Final direction |
| pred_hist_o | output | IDX_W | History used for this lookup |
| upd_valid_i | input | 1 | Update strobe |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_hist_i | input | IDX_W | History returned from the lookup of that branch |
| upd_taken_i | input | 1 | Resolved outcome |

## Verification
The lookup and the update can happen in the same cycle, and they may hit the same counter. The bench drives both on most cycles. Lookup addresses are drawn from the same 64-entry space as update addresses, so collisions on a bimodal or selector entry are frequent. A directed pair of cycles also aims a lookup at the entry being trained. The bench judges each lookup against a model that holds the pre-edge state. Its tables are written only after the outputs of that cycle have been compared, so any forwarding of an update into the same-cycle lookup shows up as a mismatch.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_LO = 2'b01;

  localparam int KIND_BIM = 0;
  localparam int KIND_GSH = 1;
  localparam int KIND_SKW = 2;
  localparam int N_COMP   = 3;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/hbp_hash.sv
module hbp_hash #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int KIND  = 0
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IDX_W-1:0] hist_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] pc_lo;
  assign pc_lo = pc_i[IDX_W-1:0];

  generate
    if (KIND == hbp_pkg::KIND_BIM) begin : g_bim
      assign idx_o = pc_lo;
    end else if (KIND == hbp_pkg::KIND_GSH) begin : g_gsh
      assign idx_o = pc_lo ^ hist_i;
    end else begin : g_skw
      logic [IDX_W-1:0] hist_rev;
      for (genvar i = 0; i < IDX_W; i++) begin : g_rev
        assign hist_rev[i] = hist_i[IDX_W-1-i];
      end
      assign idx_o = {pc_lo[IDX_W-2:0], pc_lo[IDX_W-1]} ^ hist_rev;
    end
  endgenerate
endmodule

// File: rtl/hbp_ctr_table.sv
module hbp_ctr_table
  import hbp_pkg::*;
#(
  parameter int   IDX_W   = 6,
  parameter ctr_t RST_VAL = CTR_WEAK_LO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic [IDX_W-1:0] up_idx_i,
  output ctr_t             up_ctr_o,
  input  logic             wr_en_i,
  input  logic             wr_dir_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl_q [DEPTH];

  assign rd_ctr_o = tbl_q[rd_idx_i];
  assign up_ctr_o = tbl_q[up_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= RST_VAL;
    end else if (wr_en_i) begin
      tbl_q[up_idx_i] <= ctr_step(up_ctr_o, wr_dir_i);
    end
  end

  // R2
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_dir_i && up_ctr_o == 2'b11) |=> tbl_q[$past(up_idx_i)] == 2'b11);
  // R2
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_dir_i && up_ctr_o == 2'b00) |=> tbl_q[$past(up_idx_i)] == 2'b00);
  // R7
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> tbl_q[$past(up_idx_i)] == $past(up_ctr_o));
endmodule

// File: rtl/hybrid_bp.sv
module hybrid_bp
  import hbp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_vote_i,
  input  logic [PC_W-1:0]  pred_pc_i,
  output logic             pred_bim_o,
  output logic             pred_gsh_o,
  output logic             pred_skw_o,
  output logic             pred_use_gsh_o,
  output logic             pred_taken_o,
  output logic [IDX_W-1:0] pred_hist_o,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic [IDX_W-1:0] upd_hist_i,
  input  logic             upd_taken_i
);
  localparam int HIST_W = IDX_W;

  logic [HIST_W-1:0] ghr_q;
  logic [N_COMP-1:0][IDX_W-1:0] p_idx, u_idx;
  logic [N_COMP-1:0][1:0]       p_ctr, u_ctr;
  logic [N_COMP-1:0]            p_dir, u_dir;
  ctr_t cho_p_ctr, cho_u_ctr;
  logic cho_wr_en, cho_wr_dir;

  generate
    for (genvar c = 0; c < N_COMP; c++) begin : g_comp
      hbp_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .KIND(c)) u_hash_p (
        .pc_i(pred_pc_i), .hist_i(ghr_q), .idx_o(p_idx[c]));
      hbp_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .KIND(c)) u_hash_u (
        .pc_i(upd_pc_i), .hist_i(upd_hist_i), .idx_o(u_idx[c]));
      hbp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LO)) u_tbl (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .rd_idx_i(p_idx[c]), .rd_ctr_o(p_ctr[c]),
        .up_idx_i(u_idx[c]), .up_ctr_o(u_ctr[c]),
        .wr_en_i(upd_valid_i), .wr_dir_i(upd_taken_i));
      assign p_dir[c] = p_ctr[c][1];
      assign u_dir[c] = u_ctr[c][1];
    end
  endgenerate

  // selector shares the bimodal index
  hbp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LO)) u_chooser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(p_idx[KIND_BIM]), .rd_ctr_o(cho_p_ctr),
    .up_idx_i(u_idx[KIND_BIM]), .up_ctr_o(cho_u_ctr),
    .wr_en_i(cho_wr_en), .wr_dir_i(cho_wr_dir));

  assign cho_wr_en  = upd_valid_i && (u_dir[KIND_BIM] != u_dir[KIND_GSH]);
  assign cho_wr_dir = (u_dir[KIND_GSH] == upd_taken_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ghr_q <= '0;
    else if (upd_valid_i) ghr_q <= {ghr_q[HIST_W-2:0], upd_taken_i};
  end

  logic vote;
  assign vote = (p_dir[0] & p_dir[1]) | (p_dir[0] & p_dir[2]) | (p_dir[1] & p_dir[2]);

  assign pred_bim_o     = p_dir[KIND_BIM];
  assign pred_gsh_o     = p_dir[KIND_GSH];
  assign pred_skw_o     = p_dir[KIND_SKW];
  assign pred_use_gsh_o = cho_p_ctr[1];
  assign pred_hist_o    = ghr_q;

  always_comb begin
    if (mode_vote_i)         pred_taken_o = vote;
    else if (pred_use_gsh_o) pred_taken_o = pred_gsh_o;
    else                     pred_taken_o = pred_bim_o;
  end

  // R4 R5
  agree_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_bim_o == pred_gsh_o) |-> pred_taken_o == pred_bim_o);
  // R8
  hist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> pred_hist_o[0] == $past(upd_taken_i));
  // R8
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(pred_hist_o));
endmodule

// File: tb/hybrid_bp_tb.sv
`timescale 1ns/1ps
module hybrid_bp_tb;
  localparam int PC_W  = 32;
  localparam int IDX_W = 6;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 0, rst_ni = 0;
  logic mode_vote_i = 0;
  logic [PC_W-1:0] pred_pc_i = '0, upd_pc_i = '0;
  logic [IDX_W-1:0] upd_hist_i = '0;
  logic upd_valid_i = 0, upd_taken_i = 0;
  logic pred_bim_o, pred_gsh_o, pred_skw_o, pred_use_gsh_o, pred_taken_o;
  logic [IDX_W-1:0] pred_hist_o;

  always #2 clk = ~clk;

  hybrid_bp #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_vote_i(mode_vote_i),
    .pred_pc_i(pred_pc_i), .pred_bim_o(pred_bim_o), .pred_gsh_o(pred_gsh_o),
    .pred_skw_o(pred_skw_o), .pred_use_gsh_o(pred_use_gsh_o),
    .pred_taken_o(pred_taken_o), .pred_hist_o(pred_hist_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_hist_i(upd_hist_i),
    .upd_taken_i(upd_taken_i));

  int n_chk = 0, n_bad = 0;
  int unsigned seed = 32'h1234_5678;
  int m_bim[DEPTH], m_gsh[DEPTH], m_skw[DEPTH], m_cho[DEPTH];
  int m_ghr;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed >> 8);
  endfunction

  function automatic int ix_b(int pc);
    return pc % DEPTH;
  endfunction
  function automatic int ix_g(int pc, int h);
    return (pc % DEPTH) ^ h;
  endfunction
  function automatic int ix_s(int pc, int h);
    int lo = pc % DEPTH;
    int rot = ((lo * 2) % DEPTH) + (lo / (DEPTH / 2));
    int rev = 0;
    for (int i = 0; i < IDX_W; i++) if ((h >> i) & 1) rev += 1 << (IDX_W - 1 - i);
    return rot ^ rev;
  endfunction
  function automatic int stp(int c, int up);
    if (up != 0) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic step(int md, int ppc, int uv, int upc, int uh, int ut);
    int eb, eg, es, ec, ef, ub, ug, ib, ig, is;
    @(negedge clk);
    mode_vote_i = md[0]; pred_pc_i = ppc; upd_valid_i = uv[0];
    upd_pc_i = upc; upd_hist_i = uh[IDX_W-1:0]; upd_taken_i = ut[0];
    #1;
    eb = m_bim[ix_b(ppc)] / 2;
    eg = m_gsh[ix_g(ppc, m_ghr)] / 2;
    es = m_skw[ix_s(ppc, m_ghr)] / 2;
    ec = m_cho[ix_b(ppc)] / 2;
    if (md != 0) ef = (eb + eg + es >= 2) ? 1 : 0;
    else         ef = (ec != 0) ? eg : eb;
    chk("R2/R6/R9 bimodal", pred_bim_o, eb);
    chk("R3/R6 global xor", pred_gsh_o, eg);
    chk("R3/R6 skewed", pred_skw_o, es);
    chk("R4/R7 selector", pred_use_gsh_o, ec);
    chk(md != 0 ? "R5 vote final" : "R4 selector final", pred_taken_o, ef);
    chk("R8 history", pred_hist_o, m_ghr);
    if (uv != 0) begin
      ib = ix_b(upc); ig = ix_g(upc, uh); is = ix_s(upc, uh);
      ub = m_bim[ib] / 2; ug = m_gsh[ig] / 2;
      if (ub != ug) m_cho[ib] = stp(m_cho[ib], (ug == ut) ? 1 : 0);
      m_bim[ib] = stp(m_bim[ib], ut);
      m_gsh[ig] = stp(m_gsh[ig], ut);
      m_skw[is] = stp(m_skw[is], ut);
      m_ghr = ((m_ghr * 2) % DEPTH) + ut;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_bim[i] = 1; m_gsh[i] = 1; m_skw[i] = 1; m_cho[i] = 1;
    end
    m_ghr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;

    // R1: reset state over every bimodal/selector entry
    for (int p = 0; p < DEPTH; p++) begin
      @(negedge clk); pred_pc_i = p; #1;
      chk("R1 bim", pred_bim_o, 0);
      chk("R1 gsh", pred_gsh_o, 0);
      chk("R1 skw", pred_skw_o, 0);
      chk("R1 selector", pred_use_gsh_o, 0);
      chk("R1 final", pred_taken_o, 0);
      chk("R1 hist", pred_hist_o, 0);
    end

    // R9: lookup and update on the same entry in one cycle
    step(0, 7, 1, 7, 0, 1);
    chk("R9 pre-update view", pred_bim_o, 0);
    step(0, 7, 0, 0, 0, 0);
    chk("R9 post-update view", pred_bim_o, 1);

    // R2: saturation and hysteresis on one entry
    for (int k = 0; k < 4; k++) step(0, 9, 1, 9, 0, 1);
    step(0, 9, 1, 9, 0, 0);
    step(0, 9, 0, 0, 0, 0);
    chk("R2 hysteresis", pred_bim_o, 1);

    // R7: force disagreement and let the global component win
    for (int k = 0; k < 40; k++) step(k % 2, k % 4, 1, k % 4, k % 64, (k % 3 == 0) ? 1 : 0);

    // mixed sweep, both modes, overlapping lookups and updates
    for (int k = 0; k < 4000; k++) begin
      int r = rnd();
      step((r >> 20) & 1, r % 64, ((r >> 12) % 4 != 0) ? 1 : 0,
           (k < 2000) ? (r >> 4) % 16 : (r >> 6) % 64,
           (r >> 14) % 64, ((r >> 22) % 5 < 3) ? 1 : 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule